// File: doc/BRIEF.md
# Coprocessor Command Register Engine

This block is the command port between a host processor and an internal communication coprocessor. The host loads a 32-bit argument into the data register. It then writes a 32-bit command word with the go flag set. When the block accepts that word, it splits the word into an opcode, a target field and a protocol field. Where those fields sit in the word depends on the opcode and on the target unit. The block then issues one descriptor to an execution stub.

The go flag stays set in the command register while the stub works. The host polls the command register until the flag reads zero. Only one command runs at a time. A command write that arrives while the flag is set is dropped, and a sticky overrun bit records the loss. The stub's run length comes from an input, so the timing of the busy window can be observed. The reset opcode is a special case: it carries no target or protocol field, and the stored data word does not go with it.

Top module: `cpcmd_engine`

## Requirements
- R1: A synchronous active-low reset clears the data register, the command register (including the go flag), the overrun bit and `desc_valid`. After reset, every readable address returns zero.
- R2: The register map for writes and reads is: address 0 is the data register, address 1 is the command register, address 2 returns the overrun bit in bit 0 with all other bits zero, and address 3 always reads zero.
- R3: A write to address 1 with bit 16 (the go flag) set, made while the flag is clear, is accepted. Bit 16 reads 1 from the next cycle on. `desc_valid` is high for exactly one cycle, the cycle right after the write, and for no other cycle.
- R4: With `exec_latency` = L sampled at acceptance (a value of 0 behaves as 1), the go flag reads 1 for exactly L+2 cycles. `exec_done` is high for exactly one cycle, and that cycle is the last one in which the flag reads 1.
- R5: When the command completes, only bit 16 of the command register clears. The other 31 bits read back exactly as written.
- R6: Opcode 0 (bits 31:28) is the reset command. Its descriptor has device, protocol and data all zero, whatever the other command bits and the data register hold.
- R7: Opcode 7 (page assignment) takes the device from the thread number in bits 24:17 and the protocol from bits 7:0. The descriptor data is the data register.
- R8: Opcode 6 (RISC assignment) takes the device from the thread number in bits 24:17 and the protocol from bits 15:8. The descriptor data is the data register.
- R9: Every other opcode takes the device from the unit code in bits 27:21, zero-extended to 8 bits. The protocol comes from bits 13:6, except when the unit code is 7'h13 (the USB unit), where it comes from bits 11:4. The descriptor data is the data register.
- R10: A write to address 1 while the go flag is set is ignored: there is no descriptor and the command readback does not change. The write sets the overrun bit, which stays set until reset. A write on the same edge where completion clears the flag still counts as made while busy.
- R11: A write to address 1 with bit 16 clear, made while idle, stores the word but does not start a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| exec_latency | input | 8 | Stub run length in cycles; 0 behaves as 1 |
| desc_valid | output | 1 | One-cycle descriptor strobe |
| desc_opcode | output | 4 | Descriptor opcode |
| desc_device | output | 8 | Descriptor device or thread number |
| desc_proto | output | 8 | Descriptor protocol value |
| desc_data | output | 32 | Descriptor argument word |
| exec_done | output | 1 | One-cycle completion pulse from the stub |
| overrun | output | 1 | Sticky dropped-command indicator |

## Verification
Completion clearing the go flag and a new host command write can fall on the same clock edge. The outcome on that edge decides whether the command is accepted or dropped. The bench runs a command with a latency of one cycle, waits until `exec_done` is high, and then aligns a second command write to the edge where the flag drops. It expects that write to be dropped: no descriptor appears, the first command word reads back with only its flag cleared, and the overrun bit is set. A later command on an idle engine must then still run normally.

// File: rtl/cpcmd_pkg.sv
// Shared field positions, opcodes and descriptor type for the command engine.
// Assumes a 32-bit register word and a 2-bit register address.
package cpcmd_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int OPC_W     = 4;
    localparam int DEV_W     = 8;
    localparam int PROTO_W   = 8;
    localparam int UNIT_W    = 7;

    localparam int FLAG_BIT       = 16;
    localparam int OPC_LSB        = WORD_W - OPC_W;
    localparam int UNIT_LSB       = OPC_LSB - UNIT_W;
    localparam int THREAD_LSB     = FLAG_BIT + 1;
    localparam int PROTO_LSB_NORM = 6;
    localparam int PROTO_LSB_USB  = 4;
    localparam int PROTO_LSB_RISC = 8;
    localparam int PROTO_LSB_PAGE = 0;

    localparam logic [OPC_W-1:0]  OPC_RESET = 4'h0;
    localparam logic [OPC_W-1:0]  OPC_RISC  = 4'h6;
    localparam logic [OPC_W-1:0]  OPC_PAGE  = 4'h7;
    localparam logic [UNIT_W-1:0] UNIT_USB  = 7'h13;

    typedef enum logic [ADDR_W-1:0] {
        ADR_DATA = 2'd0,
        ADR_CMD  = 2'd1,
        ADR_STAT = 2'd2,
        ADR_RSVD = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [OPC_W-1:0]   opcode;
        logic [DEV_W-1:0]   device;
        logic [PROTO_W-1:0] proto;
        logic [WORD_W-1:0]  data;
    } cmd_desc_t;
endpackage

// File: rtl/cpcmd_regs.sv
// Register file: data word, command word with go flag, sticky overrun.
// Assumes done only pulses while busy. Reads are combinational.
module cpcmd_regs
    import cpcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_flag,
    input  logic              done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] data_q,
    output logic              busy,
    output logic              start,
    output logic              overrun_q
);
    logic [WORD_W-1:0] cmd_q;
    logic              cmd_wr;
    logic              data_wr;

    // Decode the write strobes and the accept condition.
    always_comb begin
        cmd_wr  = wr_en && (wr_addr == ADR_CMD);
        data_wr = wr_en && (wr_addr == ADR_DATA);
        start   = cmd_wr && wr_flag && !busy;
    end

    assign busy = cmd_q[FLAG_BIT];

    // Hold the data, command and overrun state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            cmd_q     <= '0;
            overrun_q <= 1'b0;
        end else begin
            if (data_wr)
                data_q <= wr_data;
            if (done)
                cmd_q[FLAG_BIT] <= 1'b0;
            if (cmd_wr && !busy)
                cmd_q <= wr_data;
            if (cmd_wr && busy)
                overrun_q <= 1'b1;
        end
    end

    // Select the read word.
    always_comb begin
        case (reg_addr_e'(rd_addr))
            ADR_DATA: rd_data = data_q;
            ADR_CMD:  rd_data = cmd_q;
            ADR_STAT: rd_data = {{(WORD_W-1){1'b0}}, overrun_q};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cpcmd_decode.sv
// Field decode: turns a command word and the data word into a descriptor.
// Field positions move with the opcode and with the target unit.
module cpcmd_decode
    import cpcmd_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [WORD_W-1:0] data_word,
    output logic              flag_set,
    output cmd_desc_t         desc
);
    logic [UNIT_W-1:0] unit;

    assign flag_set = cmd_word[FLAG_BIT];
    assign unit     = cmd_word[UNIT_LSB +: UNIT_W];

    // Choose the field layout for the opcode.
    always_comb begin
        desc        = '0;
        desc.opcode = cmd_word[OPC_LSB +: OPC_W];
        if (desc.opcode != OPC_RESET) begin
            desc.data = data_word;
            if (desc.opcode == OPC_PAGE) begin
                desc.device = cmd_word[THREAD_LSB +: DEV_W];
                desc.proto  = cmd_word[PROTO_LSB_PAGE +: PROTO_W];
            end else if (desc.opcode == OPC_RISC) begin
                desc.device = cmd_word[THREAD_LSB +: DEV_W];
                desc.proto  = cmd_word[PROTO_LSB_RISC +: PROTO_W];
            end else begin
                desc.device = DEV_W'(unit);
                if (unit == UNIT_USB)
                    desc.proto = cmd_word[PROTO_LSB_USB +: PROTO_W];
                else
                    desc.proto = cmd_word[PROTO_LSB_NORM +: PROTO_W];
            end
        end
    end
endmodule

// File: rtl/cpcmd_stub.sv
// Execution stub: counts a programmed run length, then pulses done once.
// Assumes start never arrives while a run is in progress.
module cpcmd_stub #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAT_W-1:0] latency,
    output logic             done
);
    logic             running;
    logic [LAT_W-1:0] cnt;

    // Load the counter on start, count down, and pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                running <= 1'b1;
                cnt     <= (latency == '0) ? LAT_W'(1) : latency;
            end else if (running) begin
                if (cnt == LAT_W'(1)) begin
                    done    <= 1'b1;
                    running <= 1'b0;
                end else begin
                    cnt <= cnt - LAT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/cpcmd_engine.sv
// Top of the command engine: registers, decode, descriptor latch, stub.
// Assumes one host writer; the descriptor is valid for one cycle per command.
module cpcmd_engine
    import cpcmd_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0]  rd_data,
    input  logic [LAT_W-1:0]   exec_latency,
    output logic               desc_valid,
    output logic [OPC_W-1:0]   desc_opcode,
    output logic [DEV_W-1:0]   desc_device,
    output logic [PROTO_W-1:0] desc_proto,
    output logic [WORD_W-1:0]  desc_data,
    output logic               exec_done,
    output logic               overrun
);
    logic [WORD_W-1:0] data_q;
    logic              busy;
    logic              start;
    logic              wr_flag;
    cmd_desc_t         dec_desc;
    cmd_desc_t         desc_q;
    logic              desc_valid_q;

    cpcmd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_flag   (wr_flag),
        .done      (exec_done),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .data_q    (data_q),
        .busy      (busy),
        .start     (start),
        .overrun_q (overrun)
    );

    cpcmd_decode u_decode (
        .cmd_word  (wr_data),
        .data_word (data_q),
        .flag_set  (wr_flag),
        .desc      (dec_desc)
    );

    // Latch the descriptor when a command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q       <= '0;
            desc_valid_q <= 1'b0;
        end else begin
            desc_valid_q <= start;
            if (start)
                desc_q <= dec_desc;
        end
    end

    cpcmd_stub #(.LAT_W(LAT_W)) u_stub (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (desc_valid_q),
        .latency (exec_latency),
        .done    (exec_done)
    );

    assign desc_valid  = desc_valid_q;
    assign desc_opcode = desc_q.opcode;
    assign desc_device = desc_q.device;
    assign desc_proto  = desc_q.proto;
    assign desc_data   = desc_q.data;
endmodule

// File: rtl/cpcmd_engine_chk.sv
// Property checker for the command engine, attached by bind.
// Assumes it sees the top's internal busy flag and its ports.
module cpcmd_engine_chk
    import cpcmd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic               desc_valid,
    input logic [OPC_W-1:0]   desc_opcode,
    input logic [DEV_W-1:0]   desc_device,
    input logic [PROTO_W-1:0] desc_proto,
    input logic [WORD_W-1:0]  desc_data,
    input logic               exec_done,
    input logic               overrun
);
    // R3
    desc_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |=> !desc_valid);
    // R3
    desc_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> busy);
    // R4
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_done |-> busy);
    // R4
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_done |=> !busy);
    // R6
    reset_opc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_opcode == OPC_RESET) |->
            (desc_device == '0 && desc_proto == '0 && desc_data == '0));
    // R10
    busy_write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_addr == ADR_CMD) |=> overrun);
    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind cpcmd_engine cpcmd_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .desc_valid  (desc_valid),
    .desc_opcode (desc_opcode),
    .desc_device (desc_device),
    .desc_proto  (desc_proto),
    .desc_data   (desc_data),
    .exec_done   (exec_done),
    .overrun     (overrun)
);

// File: tb/cpcmd_engine_tb.sv
// Scoreboard bench: the driver queues expected descriptors, the monitor compares them.
module cpcmd_engine_tb;
    import cpcmd_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic [WORD_W-1:0]  wr_data = '0;
    logic [ADDR_W-1:0]  rd_addr = '0;
    logic [WORD_W-1:0]  rd_data;
    logic [7:0]         exec_latency = 8'd1;
    logic               desc_valid;
    logic [OPC_W-1:0]   desc_opcode;
    logic [DEV_W-1:0]   desc_device;
    logic [PROTO_W-1:0] desc_proto;
    logic [WORD_W-1:0]  desc_data;
    logic               exec_done;
    logic               overrun;

    int errors = 0;
    int checks = 0;
    cmd_desc_t exp_q[$];

    always #2 clk = ~clk;

    cpcmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .exec_latency(exec_latency), .desc_valid(desc_valid),
        .desc_opcode(desc_opcode), .desc_device(desc_device),
        .desc_proto(desc_proto), .desc_data(desc_data),
        .exec_done(exec_done), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: pop and compare each descriptor as it appears.
    always @(negedge clk) begin
        if (rst_n && desc_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected descriptor", {4'h0, desc_opcode, 56'h0}, 64'h0);
            end else begin
                cmd_desc_t e;
                e = exp_q.pop_front();
                check({desc_opcode, desc_device, desc_proto, desc_data} == e,
                      "R3/R6-R9 descriptor",
                      64'({desc_opcode, desc_device, desc_proto, desc_data}), 64'(e));
            end
        end
    end

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic issue(input logic [31:0] data, input logic [31:0] word,
                         input cmd_desc_t e);
        wr(2'd0, data);
        exp_q.push_back(e);
        wr(2'd1, word);
    endtask

    // Measure busy length and done position, right after an accepted write (R4).
    task automatic measure(input int lat, input string req);
        int cnt = 0;
        int dones = 0;
        bit last_done = 1'b0;
        logic [31:0] v;
        for (int guard = 0; guard < 600; guard++) begin
            rd(2'd1, v);
            if (!v[16]) break;
            cnt++;
            last_done = exec_done;
            if (exec_done) dones++;
            @(negedge clk);
        end
        check(cnt == lat + 2, req, 64'(cnt), 64'(lat + 2));
        check(dones == 1 && last_done, {req, " done pulse"}, 64'(dones), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] w;
        cmd_desc_t e;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: everything reads zero after reset
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v == 32'h0, "R1 reset readback", 64'(v), 64'h0);
        end
        check(!overrun && !desc_valid, "R1 reset outputs", 64'({overrun, desc_valid}), 64'h0);

        // R2: register map
        @(negedge clk);
        wr(2'd0, 32'hCAFE_0123);
        rd(2'd0, v); check(v == 32'hCAFE_0123, "R2 data readback", 64'(v), 64'hCAFE_0123);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); check(v == 32'h0, "R2 address 3 reads zero", 64'(v), 64'h0);

        // R11: flag clear stores without starting
        wr(2'd1, 32'h3000_0040);
        check(!desc_valid, "R11 no descriptor", 64'(desc_valid), 64'h0);
        rd(2'd1, v); check(v == 32'h3000_0040, "R11 stored word", 64'(v), 64'h3000_0040);
        @(negedge clk);

        // R9 normal unit, R4 latency 5, R5 completion readback
        exec_latency = 8'd5;
        w = (32'h3 << 28) | (32'h05 << 21) | (32'h5A << 6) | (32'h1 << 16);
        e = '{opcode:4'h3, device:8'h05, proto:8'h5A, data:32'hA5A5_1234};
        issue(32'hA5A5_1234, w, e);
        measure(5, "R4 busy length L=5");
        rd(2'd1, v); check(v == (w & ~32'h0001_0000), "R5 flag cleared only", 64'(v), 64'(w & ~32'h0001_0000));

        // R9 USB unit uses the alternate protocol position; R4 latency 0
        exec_latency = 8'd0;
        w = (32'h2 << 28) | (32'h13 << 21) | (32'hC3 << 4) | (32'h1 << 16);
        e = '{opcode:4'h2, device:8'h13, proto:8'hC3, data:32'h0000_BEEF};
        issue(32'h0000_BEEF, w, e);
        measure(1, "R4 busy length L=0");

        // R7 page assignment
        exec_latency = 8'd2;
        w = (32'h7 << 28) | (32'h89 << 17) | 32'h3C | (32'h1 << 16);
        e = '{opcode:4'h7, device:8'h89, proto:8'h3C, data:32'h1111_2222};
        issue(32'h1111_2222, w, e);
        measure(2, "R7 busy length L=2");

        // R8 RISC assignment
        w = (32'h6 << 28) | (32'hD8 << 17) | (32'h02 << 8) | (32'h1 << 16);
        e = '{opcode:4'h6, device:8'hD8, proto:8'h02, data:32'h3333_4444};
        issue(32'h3333_4444, w, e);
        measure(2, "R8 busy length L=2");

        // R6 reset opcode ignores extra bits and the data register
        w = 32'h0FFF_3FC0 | (32'h1 << 16);
        e = '{opcode:4'h0, device:8'h00, proto:8'h00, data:32'h0};
        issue(32'hDEAD_BEEF, w, e);
        measure(2, "R6 busy length L=2");

        // R10 write on the completion edge is dropped and flags overrun
        exec_latency = 8'd1;
        w = (32'h4 << 28) | (32'h02 << 21) | (32'h11 << 6) | (32'h1 << 16);
        e = '{opcode:4'h4, device:8'h02, proto:8'h11, data:32'h5555_6666};
        issue(32'h5555_6666, w, e);
        @(negedge clk);
        @(negedge clk);
        check(exec_done, "R10 aligned to done", 64'(exec_done), 64'h1);
        wr(2'd1, (32'h5 << 28) | (32'h1 << 16));
        check(!desc_valid, "R10 dropped write no descriptor", 64'(desc_valid), 64'h0);
        check(overrun, "R10 overrun set", 64'(overrun), 64'h1);
        rd(2'd1, v); check(v == (w & ~32'h0001_0000), "R10 readback unchanged", 64'(v), 64'(w & ~32'h0001_0000));
        rd(2'd2, v); check(v == 32'h1, "R2 status overrun bit", 64'(v), 64'h1);

        // R10 sticky across a later good command
        w = (32'h9 << 28) | (32'h01 << 21) | (32'h7E << 6) | (32'h1 << 16);
        e = '{opcode:4'h9, device:8'h01, proto:8'h7E, data:32'h7777_8888};
        @(negedge clk);
        issue(32'h7777_8888, w, e);
        measure(1, "R4 busy length L=1");
        check(overrun, "R10 overrun sticky", 64'(overrun), 64'h1);

        // R1 reset clears overrun and registers
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd2, v); check(v == 32'h0 && !overrun, "R1 overrun cleared", 64'(v), 64'h0);
        rd(2'd0, v); check(v == 32'h0, "R1 data cleared", 64'(v), 64'h0);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R3 all descriptors seen", 64'(exp_q.size()), 64'h0);
        finish_run();
    end
endmodule